// File: doc/BRIEF.md
# Main Clock Loss Monitor with Backup Failover

This block compares a main clock against a free-running reference clock. A toggle that the main clock drives is synchronized into the reference domain. A counter measures how long that toggle has gone without changing. When the counter reaches its limit, the main clock is declared dead. The system clock output then moves to a slower backup clock through a glitch-free handover. A sticky detection flag is set, and an interrupt can be raised from it.

After reset, no failover is possible until the first main-clock activity is seen, and the system is held in reset until then. In halt mode the monitor is stopped and the backup source is switched off. When halt ends, the control settings are kept if the wake came from an interrupt, and reloaded to their defaults if the wake came from a reset-class source. In wait and active-halt modes the monitor keeps running, and a detection interrupt produces a wake request. Once the system runs on the backup clock, it stays there until the next reset.

Top module: `clk_guard`

## Requirements
- R1: After reset, `rst_hold_o` stays 1 and no failover can occur until a main-clock edge has been seen in the reference domain. After that, `rst_hold_o` is 0.
- R2: While the monitor is active, `sel_bkp_o` rises when the main clock shows no edge for LOSS_CYCLES reference cycles. The monitor is active when it is enabled, the mode is not halt, and the main clock has been seen.
- R3: `sys_clk_o` carries the main clock before failover and the backup clock after it. The two sources are never enabled together. The selection stays on the backup clock until reset, even if the main clock comes back.
- R4: Status bit 0 (address 1) is set when failover happens and stays set. Writing 1 to it clears it. Writing 0 to it has no effect.
- R5: `irq_o` is 1 only when the detection flag is 1, control bit 1 (interrupt enable) is 1, and `gmask_i` is 0.
- R6: With control bit 0 (monitor enable) at 0, a stopped main clock causes no failover and sets no flag.
- R7: In halt mode (`mode_i`=3), a stopped main clock causes no failover, and `bkp_on_o` is 0. Outside halt, `bkp_on_o` equals the monitor enable bit.
- R8: When `mode_i` leaves 3, the control register keeps its value if `wake_rst_i` is 0. If `wake_rst_i` is 1, the control register returns to its reset value.
- R9: In wait (`mode_i`=1) and active-halt (`mode_i`=2), the monitor stays active and `wake_o` follows `irq_o`. In run (`mode_i`=0), `wake_o` is 0.
- R10: Address 0 reads the control register: bit 0 is the enable and bit 1 is the interrupt enable. Address 1 reads the status register, with the flag in bit 0. All other bits read 0. After reset, the enable is MON_EN_RST and the interrupt enable is 0. Writes take effect on the next reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; also clocks the register port |
| clk_main_i | input | 1 | Main clock being watched |
| clk_bkp_i | input | 1 | Lower-frequency backup clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| gmask_i | input | 1 | Global interrupt mask (1 = masked) |
| mode_i | input | 2 | Power mode: 0 run, 1 wait, 2 active-halt, 3 halt |
| wake_rst_i | input | 1 | Halt exit comes from a reset-class source |
| sys_clk_o | output | 1 | Selected system clock |
| sel_bkp_o | output | 1 | Failover has occurred (sticky) |
| bkp_on_o | output | 1 | Backup source requested to run |
| rst_hold_o | output | 1 | Hold system in reset until main clock seen |
| irq_o | output | 1 | Detection interrupt |
| wake_o | output | 1 | Wake request from wait or active-halt |

## Verification
The bench builds the block with LOSS_CYCLES=6, SYNC_STAGES=2, MON_EN_RST=1 and DATA_W=8. The main clock runs at 10 ns, the backup at 14 ns and the reference at 4 ns. With a limit of six, a healthy main clock never comes near the threshold. A stopped main clock is declared dead within about a dozen reference cycles, so every failover, halt and wait scenario fits in short windows. Clock-source selection is checked by counting system-clock edges over a fixed window, because the two source rates give separate count ranges.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_WAIT  = 2'd1,
    MODE_AHALT = 2'd2,
    MODE_HALT  = 2'd3
  } pwr_mode_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int STAT_DET_BIT = 0;
endpackage

// File: rtl/clk_guard_sync.sv
module clk_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/clk_guard_detect.sv
module clk_guard_detect #(
  parameter int LOSS_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref_i,
  input  logic clk_main_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic halt_i,
  output logic seen_o,
  output logic switched_o
);
  localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_CYCLES);

  logic             tog_q;
  logic             tog_s;
  logic             tog_d;
  logic             edge_s;
  logic             seen_q;
  logic             switched_q;
  logic             active;
  logic [CNT_W-1:0] cnt_q;

  // toggle in main domain; carries activity across
  always_ff @(posedge clk_main_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  clk_guard_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .d_i    (tog_q),
    .q_o    (tog_s)
  );

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) tog_d <= 1'b0;
    else         tog_d <= tog_s;
  end

  assign edge_s = tog_s ^ tog_d;
  assign active = mon_en_i && !halt_i && seen_q && !switched_q;

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= 1'b0;
    else if (edge_s)             seen_q <= 1'b1;
  end

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active || edge_s)  cnt_q <= '0;
    else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni)                          switched_q <= 1'b0;
    else if (active && cnt_q == CNT_MAX)  switched_q <= 1'b1;
  end

  assign seen_o     = seen_q;
  assign switched_o = switched_q;

  // R7
  halt_freeze_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (halt_i && $past(halt_i)) |-> $stable(switched_q));
endmodule

// File: rtl/clk_guard_switch.sv
module clk_guard_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_main_i,
  input  logic clk_bkp_i,
  input  logic rst_ni,
  input  logic sel_bkp_i,
  output logic sys_clk_o,
  output logic bkp_en_o
);
  logic main_en_q;
  logic bkp_req;
  logic bkp_req_s;
  logic bkp_en_q;

  // main may be dead: clear asynchronously on selection
  always_ff @(negedge clk_main_i or negedge rst_ni or posedge sel_bkp_i) begin
    if (!rst_ni)        main_en_q <= 1'b1;
    else if (sel_bkp_i) main_en_q <= 1'b0;
    else                main_en_q <= 1'b1;
  end

  assign bkp_req = sel_bkp_i && !main_en_q;

  clk_guard_sync #(.STAGES(SYNC_STAGES)) u_bkp_sync (
    .clk_i  (clk_bkp_i),
    .rst_ni (rst_ni),
    .d_i    (bkp_req),
    .q_o    (bkp_req_s)
  );

  always_ff @(negedge clk_bkp_i or negedge rst_ni) begin
    if (!rst_ni) bkp_en_q <= 1'b0;
    else         bkp_en_q <= bkp_req_s;
  end

  assign sys_clk_o = (clk_main_i & main_en_q) | (clk_bkp_i & bkp_en_q);
  assign bkp_en_o  = bkp_en_q;

  // R3
  always_comb begin
    if (rst_ni) begin
      src_mutex_chk: assert (!(main_en_q && bkp_en_q));
    end
  end
endmodule

// File: rtl/clk_guard_regs.sv
module clk_guard_regs
  import clk_guard_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter logic MON_EN_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              gmask_i,
  input  logic [1:0]        mode_i,
  input  logic              wake_rst_i,
  input  logic              switched_i,
  output logic              mon_en_o,
  output logic              halt_o,
  output logic              bkp_on_o,
  output logic              irq_o,
  output logic              wake_o
);
  pwr_mode_e mode;
  pwr_mode_e mode_q;
  logic      en_q;
  logic      ie_q;
  logic      flag_q;
  logic      sw_d;
  logic      sw_rise;
  logic      halt_exit;
  logic      wr_ctrl;
  logic      wr_stat;

  assign mode      = pwr_mode_e'(mode_i);
  assign halt_exit = (mode_q == MODE_HALT) && (mode != MODE_HALT);
  assign wr_ctrl   = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat   = wr_i && (addr_i == ADDR_STAT);
  assign sw_rise   = switched_i && !sw_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      sw_d   <= 1'b0;
    end else begin
      mode_q <= mode;
      sw_d   <= switched_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= MON_EN_RST;
      ie_q <= 1'b0;
    end else if (halt_exit && wake_rst_i) begin
      en_q <= MON_EN_RST;
      ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= wdata_i[CTRL_EN_BIT];
      ie_q <= wdata_i[CTRL_IE_BIT];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            flag_q <= 1'b0;
    else if (sw_rise)                       flag_q <= 1'b1;
    else if (wr_stat && wdata_i[STAT_DET_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[CTRL_EN_BIT] = en_q;
      rdata_o[CTRL_IE_BIT] = ie_q;
    end else begin
      rdata_o[STAT_DET_BIT] = flag_q;
    end
  end

  assign mon_en_o = en_q;
  assign halt_o   = (mode == MODE_HALT);
  assign bkp_on_o = en_q && (mode != MODE_HALT);
  assign irq_o    = flag_q && ie_q && !gmask_i;
  assign wake_o   = irq_o && ((mode == MODE_WAIT) || (mode == MODE_AHALT));

  // R4
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> switched_i);
endmodule

// File: rtl/clk_guard.sv
module clk_guard #(
  parameter int   DATA_W      = 8,
  parameter int   LOSS_CYCLES = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic MON_EN_RST  = 1'b1
) (
  input  logic              clk_ref_i,
  input  logic              clk_main_i,
  input  logic              clk_bkp_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              gmask_i,
  input  logic [1:0]        mode_i,
  input  logic              wake_rst_i,
  output logic              sys_clk_o,
  output logic              sel_bkp_o,
  output logic              bkp_on_o,
  output logic              rst_hold_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic mon_en;
  logic halt;
  logic seen;
  logic switched;
  logic bkp_en;

  clk_guard_regs #(
    .DATA_W     (DATA_W),
    .MON_EN_RST (MON_EN_RST)
  ) u_regs (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .gmask_i    (gmask_i),
    .mode_i     (mode_i),
    .wake_rst_i (wake_rst_i),
    .switched_i (switched),
    .mon_en_o   (mon_en),
    .halt_o     (halt),
    .bkp_on_o   (bkp_on_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  clk_guard_detect #(
    .LOSS_CYCLES (LOSS_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_detect (
    .clk_ref_i  (clk_ref_i),
    .clk_main_i (clk_main_i),
    .rst_ni     (rst_ni),
    .mon_en_i   (mon_en),
    .halt_i     (halt),
    .seen_o     (seen),
    .switched_o (switched)
  );

  clk_guard_switch #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_switch (
    .clk_main_i (clk_main_i),
    .clk_bkp_i  (clk_bkp_i),
    .rst_ni     (rst_ni),
    .sel_bkp_i  (switched),
    .sys_clk_o  (sys_clk_o),
    .bkp_en_o   (bkp_en)
  );

  assign sel_bkp_o  = switched;
  assign rst_hold_o = !seen;

  // R1
  hold_no_bkp_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    rst_hold_o |-> !bkp_en);
endmodule

// File: tb/clk_guard_bench.sv
module clk_guard_bench;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic       addr;
    logic       wr;
    logic [7:0] wdata;
    logic       gmask;
    logic [7:0] exp_rd;
    logic       exp_irq;
    logic [3:0] req;
  } vec_t;

  // register walk after a failover: flag=1, ctrl=01 at entry
  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b1, 8'h03, 1'b1, 8'h03, 1'b0, 4'd5},
    '{1'b1, 1'b1, 8'h00, 1'b0, 8'h01, 1'b1, 4'd4},
    '{1'b0, 1'b1, 8'h01, 1'b0, 8'h01, 1'b0, 4'd5},
    '{1'b0, 1'b1, 8'hFF, 1'b0, 8'h03, 1'b1, 4'd10},
    '{1'b1, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 4'd4},
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b0, 4'd4}
  };

  logic       clk = 1'b0;
  logic       clk_main = 1'b0;
  logic       clk_bkp = 1'b0;
  logic       main_run = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gmask = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       wake_rst = 1'b0;
  logic       sys_clk, sel_bkp, bkp_on, rst_hold, irq, wake;

  int n_chk = 0;
  int n_err = 0;
  int sys_cnt = 0;

  always #2 clk = ~clk;
  always #7 clk_bkp = ~clk_bkp;
  always begin
    #5;
    if (main_run) clk_main = ~clk_main;
    else          clk_main = 1'b0;
  end
  always @(posedge sys_clk) sys_cnt++;

  clk_guard #(
    .DATA_W(8), .LOSS_CYCLES(6), .SYNC_STAGES(2), .MON_EN_RST(1'b1)
  ) u_clk_guard (
    .clk_ref_i(clk), .clk_main_i(clk_main), .clk_bkp_i(clk_bkp), .rst_ni(rst_n),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .gmask_i(gmask), .mode_i(mode), .wake_rst_i(wake_rst),
    .sys_clk_o(sys_clk), .sel_bkp_o(sel_bkp), .bkp_on_o(bkp_on),
    .rst_hold_o(rst_hold), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1 d = rdata;
  endtask

  task automatic edges(output int n);
    int c0;
    @(negedge clk);
    c0 = sys_cnt;
    repeat (100) @(negedge clk);
    n = sys_cnt - c0;
  endtask

  initial begin
    #150000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;

    // startup with main absent
    cyc(5);
    rst_n = 1'b1;
    cyc(30);
    chk("R1 hold while main absent", rst_hold, 1'b1);
    chk("R1 no failover before main seen", sel_bkp, 1'b0);
    rd_reg(1'b0, d);
    chk("R10 ctrl reset value", d, 8'h01);
    rd_reg(1'b1, d);
    chk("R10 status reset value", d, 8'h00);
    main_run = 1'b1;
    cyc(12);
    chk("R1 hold released", rst_hold, 1'b0);
    edges(n);
    chk_rng("R3 sys clock from main", n, 38, 42);
    chk("R7 bkp_on in run with enable", bkp_on, 1'b1);

    // R6 disabled monitor
    wr_reg(1'b0, 8'h00);
    main_run = 1'b0;
    cyc(40);
    chk("R6 no failover when disabled", sel_bkp, 1'b0);
    rd_reg(1'b1, d);
    chk("R6 no flag when disabled", d, 8'h00);
    wr_reg(1'b0, 8'h03);
    main_run = 1'b1;
    cyc(12);

    // R7 halt
    @(negedge clk); mode = 2'd3;
    cyc(2);
    chk("R7 bkp_on off in halt", bkp_on, 1'b0);
    main_run = 1'b0;
    cyc(40);
    chk("R7 no failover in halt", sel_bkp, 1'b0);
    main_run = 1'b1;
    cyc(12);
    // R8 interrupt wake keeps control
    @(negedge clk); wake_rst = 1'b0; mode = 2'd0;
    cyc(2);
    rd_reg(1'b0, d);
    chk("R8 ctrl kept on interrupt wake", d, 8'h03);
    @(negedge clk); mode = 2'd3;
    cyc(3);
    @(negedge clk); wake_rst = 1'b1; mode = 2'd0;
    @(negedge clk); wake_rst = 1'b0;
    rd_reg(1'b0, d);
    chk("R8 ctrl reloaded on reset wake", d, 8'h01);

    // R2 failover in run
    gmask = 1'b1;
    main_run = 1'b0;
    cyc(30);
    chk("R2 failover after main stop", sel_bkp, 1'b1);
    rd_reg(1'b1, d);
    chk("R4 flag set on failover", d, 8'h01);
    chk("R5 irq low with enable off", irq, 1'b0);
    cyc(20);
    edges(n);
    chk_rng("R3 sys clock from backup", n, 26, 30);
    main_run = 1'b1;
    cyc(40);
    chk("R3 selection sticky after main returns", sel_bkp, 1'b1);
    edges(n);
    chk_rng("R3 still on backup after main returns", n, 26, 30);

    // register vector walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr = VEC[i].addr; wr = VEC[i].wr; wdata = VEC[i].wdata; gmask = VEC[i].gmask;
      @(negedge clk);
      wr = 1'b0;
      #1;
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rdata, VEC[i].exp_rd);
      chk($sformatf("R%0d vec %0d irq", VEC[i].req, i), irq, VEC[i].exp_irq);
    end

    // second reset, main running; detection in wait mode
    @(negedge clk); rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(12);
    chk("R3 selection cleared by reset", sel_bkp, 1'b0);
    chk("R1 hold released with main running", rst_hold, 1'b0);
    rd_reg(1'b1, d);
    chk("R10 status cleared by reset", d, 8'h00);
    wr_reg(1'b0, 8'h03);
    gmask = 1'b0;
    @(negedge clk); mode = 2'd1;
    main_run = 1'b0;
    cyc(30);
    chk("R9 failover in wait", sel_bkp, 1'b1);
    chk("R9 irq in wait", irq, 1'b1);
    chk("R9 wake in wait", wake, 1'b1);
    @(negedge clk); mode = 2'd2;
    #1 chk("R9 wake in active-halt", wake, 1'b1);
    @(negedge clk); mode = 2'd0;
    #1 chk("R9 no wake in run", wake, 1'b0);
    chk("R5 irq still set in run", irq, 1'b1);
    @(negedge clk); gmask = 1'b1;
    #1 chk("R5 irq masked globally", irq, 1'b0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule